// File: doc/BRIEF.md
# SONET Frame Synchronizer

This block watches an STS-48 stream that arrives as 32-bit words, already byte-aligned, and decides whether the receiver is locked to the frame. The frame marker is one word of four A1 bytes followed directly by one word of four A2 bytes. While hunting, the block looks for that word pair at every position. When it finds the pair, it starts a row and column word counter in phase with the pair. After that, it tests the marker only at the two word slots where the counter expects it.

Confidence builds and decays through six states: search, first-seen, locked, and three miss states. Two frames in a row with a good marker give lock. Four frames in a row with a bad marker return the block to search. A fast-mode input cuts both rules down to a single frame. Outputs are an out-of-frame alarm level, a lock indicator, a one-cycle interrupt when lock is lost, and a one-cycle frame pulse at the marker slot. The frame size is set by parameters; the defaults give the 9-row by 1080-word STS-48 frame.

Top module: `sfs_framer`

## Requirements
- R1: After reset `oof_alarm` is 1 and `in_frame`, `oof_irq` and `frame_pulse` are 0. They stay that way while no marker arrives.
- R2: A marker is the word 0xF6F6F6F6 directly followed by the word 0x28282828. A word pair that differs from this in any byte is not a marker.
- R3: In regular mode (`fast_en`=0), a first marker found in search drops `oof_alarm` but leaves `in_frame` at 0. A second marker exactly one frame later sets `in_frame`.
- R4: If the marker is missing one frame after the first marker in search, the block returns to search with `oof_alarm`=1.
- R5: In regular mode, once locked, the first, second and third consecutive bad frames leave `oof_alarm` at 0 and `in_frame` at 0. The fourth consecutive bad frame raises `oof_alarm`.
- R6: A good marker after one, two or three bad frames restores `in_frame`=1 and restarts the bad-frame count.
- R7: With `fast_en`=1, one marker in search sets `in_frame`, and one bad frame while locked returns to search.
- R8: Once out of search, the marker is tested only at frame words 0 and 1, where a frame is ROWS*COL_WORDS words counted from the marker found in search. A marker at any other word counts as a bad frame.
- R9: In search, a marker at any word offset sets the frame phase. The next expected marker lies exactly one frame length later.
- R10: `oof_irq` is high for exactly one cycle, in the first cycle of search, on each change from another state into search. It does not fire after reset.
- R11: Outside search, `frame_pulse` is high for one cycle per frame, in the cycle of frame word 0. It stays low in search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_en | input | 1 | 1 selects single-frame lock and single-frame loss |
| word_in | input | 32 | Byte-aligned data word, one per clock |
| frame_pulse | output | 1 | One-cycle pulse at frame word 0 while not in search |
| oof_alarm | output | 1 | High only in the search state |
| in_frame | output | 1 | High only in the locked state |
| oof_irq | output | 1 | One-cycle pulse on entry to search |

## Verification
The assertions assume one valid word on every clock, with no gaps. They also assume `fast_en` is held steady for the whole of a lock or loss sequence, and that the frame is at least three words wide, so the reload slot after the marker lies inside row 0. The bench drives a word on every cycle and changes `fast_en` only while reset is held. Its filler words are all zero, so a marker appears only where a test places one on purpose.

// File: rtl/sfs_pkg.sv
// Shared types and constants for the frame synchronizer.
// Assumes 32-bit byte-aligned words carrying four framing bytes each.
package sfs_pkg;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] A1_WORD = 32'hF6F6_F6F6;
    localparam logic [WORD_W-1:0] A2_WORD = 32'h2828_2828;

    typedef enum logic [2:0] {
        ST_SEARCH = 3'd0,
        ST_FIRST  = 3'd1,
        ST_LOCK   = 3'd2,
        ST_MISS1  = 3'd3,
        ST_MISS2  = 3'd4,
        ST_MISS3  = 3'd5
    } sfs_state_e;
endpackage

// File: rtl/sfs_pattern_det.sv
// Marker detector: flags an A1 word followed directly by an A2 word.
// Assumes one word per clock. The hit is valid in the cycle of the A2 word.
module sfs_pattern_det
    import sfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    output logic              hit
);
    logic a1_seen_q;

    // Remember whether the previous word was an A1 word.
    always_ff @(posedge clk) begin
        if (!rst_n) a1_seen_q <= 1'b0;
        else        a1_seen_q <= (word_in == A1_WORD);
    end

    // Marker seen when an A2 word follows an A1 word.
    always_comb hit = a1_seen_q && (word_in == A2_WORD);
endmodule

// File: rtl/sfs_frame_timer.sv
// Row/column word counter that keeps frame phase.
// Position (0,0) is the A1 slot and (0,1) is the A2 slot.
// A load puts the counter at the word after the A2 slot.
// Assumes COL_WORDS >= 3 and ROWS >= 2.
module sfs_frame_timer #(
    parameter int ROWS      = 9,
    parameter int COL_WORDS = 1080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic active,
    output logic at_a1,
    output logic at_a2,
    output logic frame_pulse
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COL_WORDS);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COL_WORDS - 1);
    localparam logic [COL_W-1:0] COL_RELOAD = COL_W'(2);

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    // Advance column, then row, wrapping at the frame end; reload on marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load) begin
            row_q <= '0;
            col_q <= COL_RELOAD;
        end else if (col_q == COL_LAST) begin
            col_q <= '0;
            row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
        end else begin
            col_q <= col_q + 1'b1;
        end
    end

    // Decode the two marker slots and the frame pulse.
    always_comb begin
        at_a1       = (row_q == '0) && (col_q == '0);
        at_a2       = (row_q == '0) && (col_q == COL_W'(1));
        frame_pulse = at_a1 && active;
    end

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q <= COL_LAST) && (row_q <= ROW_LAST)); // R8
    AST_RELOAD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (row_q == '0) && (col_q == COL_RELOAD)); // R9
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> !frame_pulse); // R11
endmodule

// File: rtl/sfs_sync_fsm.sv
// Six-state frame confidence machine.
// Search reacts to a marker at any position. The other states judge the
// marker only at the expected A2 slot (at_check).
// Assumes fast_en is steady across a lock or loss sequence.
module sfs_sync_fsm
    import sfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fast_en,
    input  logic hit,
    input  logic at_check,
    output logic load,
    output logic oof_alarm,
    output logic in_frame,
    output logic oof_irq
);
    sfs_state_e state_q, state_d;
    logic       irq_q;

    // Next-state rules for lock and loss in regular and fast mode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH: if (hit) state_d = fast_en ? ST_LOCK : ST_FIRST;
            ST_FIRST:  if (at_check) state_d = hit ? ST_LOCK : ST_SEARCH;
            ST_LOCK:   if (at_check && !hit) state_d = fast_en ? ST_SEARCH : ST_MISS1;
            ST_MISS1:  if (at_check) state_d = hit ? ST_LOCK : (fast_en ? ST_SEARCH : ST_MISS2);
            ST_MISS2:  if (at_check) state_d = hit ? ST_LOCK : (fast_en ? ST_SEARCH : ST_MISS3);
            ST_MISS3:  if (at_check) state_d = hit ? ST_LOCK : ST_SEARCH;
            default:   state_d = ST_SEARCH;
        endcase
    end

    // State register and one-cycle interrupt on entry to search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= (state_d == ST_SEARCH) && (state_q != ST_SEARCH);
        end
    end

    // Drive the status outputs and the counter reload.
    always_comb begin
        load      = (state_q == ST_SEARCH) && hit;
        oof_alarm = (state_q == ST_SEARCH);
        in_frame  = (state_q == ST_LOCK);
        oof_irq   = irq_q;
    end

    AST_IRQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        oof_irq |-> $rose(oof_alarm)); // R10
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        oof_irq |=> !oof_irq); // R10
    AST_FAST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (oof_alarm && hit && fast_en) |=> in_frame); // R7
    AST_FIRST_NOT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (oof_alarm && hit && !fast_en) |=> (!in_frame && !oof_alarm)); // R3
    AST_FIRST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && at_check && !hit && !fast_en) |=> (!oof_alarm && !in_frame)); // R5
    AST_MISS_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_MISS1 || state_q == ST_MISS2 || state_q == ST_MISS3)
          && at_check && hit) |=> in_frame); // R6
endmodule

// File: rtl/sfs_framer.sv
// Top level of the frame synchronizer: marker detector, frame timer and
// confidence machine. Assumes one byte-aligned 32-bit word per clock.
module sfs_framer #(
    parameter int ROWS      = 9,
    parameter int COL_WORDS = 1080
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast_en,
    input  logic [31:0] word_in,
    output logic        frame_pulse,
    output logic        oof_alarm,
    output logic        in_frame,
    output logic        oof_irq
);
    logic hit;
    logic load;
    logic at_a1;
    logic at_a2;

    sfs_pattern_det u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (word_in),
        .hit     (hit)
    );

    sfs_frame_timer #(
        .ROWS      (ROWS),
        .COL_WORDS (COL_WORDS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .active      (!oof_alarm),
        .at_a1       (at_a1),
        .at_a2       (at_a2),
        .frame_pulse (frame_pulse)
    );

    sfs_sync_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_en   (fast_en),
        .hit       (hit),
        .at_check  (at_a2),
        .load      (load),
        .oof_alarm (oof_alarm),
        .in_frame  (in_frame),
        .oof_irq   (oof_irq)
    );

    AST_ALARM_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(oof_alarm && in_frame)); // R1
    AST_NO_PULSE_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        oof_alarm |-> !frame_pulse); // R11
endmodule

// File: tb/sfs_framer_tb.sv
module sfs_framer_tb;
    localparam int ROWS  = 3;
    localparam int COLW  = 8;
    localparam int FRAME = ROWS * COLW;
    localparam logic [31:0] A1 = 32'hF6F6_F6F6;
    localparam logic [31:0] A2 = 32'h2828_2828;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_en = 1'b0;
    logic [31:0] word_in = '0;
    logic        frame_pulse, oof_alarm, in_frame, oof_irq;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    int p_at0 = 0;
    int p_other = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sfs_framer #(.ROWS(ROWS), .COL_WORDS(COLW)) u_dut (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .word_in(word_in),
        .frame_pulse(frame_pulse), .oof_alarm(oof_alarm),
        .in_frame(in_frame), .oof_irq(oof_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one word and sample the outputs for that cycle.
    task automatic put_word(input logic [31:0] w, input int idx);
        @(negedge clk);
        word_in = w;
        #1;
        if (oof_irq) irq_cnt++;
        if (frame_pulse) begin
            if (idx == 0) p_at0++;
            else          p_other++;
        end
    endtask

    // One frame: words m0,m1 placed at offset off, zeros elsewhere.
    task automatic send_frame(input logic [31:0] m0, input logic [31:0] m1, input int off);
        p_at0 = 0;
        p_other = 0;
        for (int i = 0; i < FRAME; i++) begin
            if (i == off)          put_word(m0, i);
            else if (i == off + 1) put_word(m1, i);
            else                   put_word('0, i);
        end
    endtask

    task automatic good();  send_frame(A1, A2, 0); endtask
    task automatic nogood(); send_frame('0, '0, 0); endtask

    task automatic do_reset(input logic fast);
        @(negedge clk);
        rst_n = 1'b0;
        fast_en = fast;
        word_in = '0;
        repeat (3) @(negedge clk);
        #1;
        irq_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 alarm", oof_alarm, 1);
        chk("R1 in_frame", in_frame, 0);
        chk("R1 irq", oof_irq, 0);
        chk("R1 pulse", frame_pulse, 0);
        nogood(); nogood();
        chk("R1 alarm idle", oof_alarm, 1);
        chk("R10 no irq after reset", irq_cnt, 0);
        chk("R11 no pulse in search", p_at0 + p_other, 0);
    endtask

    task automatic t_regular_lock();
        do_reset(1'b0);
        good();
        chk("R3 first marker alarm", oof_alarm, 0);
        chk("R3 first marker in_frame", in_frame, 0);
        good();
        chk("R3 second marker in_frame", in_frame, 1);
        good();
        chk("R11 pulse at word0", p_at0, 1);
        chk("R11 no pulse elsewhere", p_other, 0);
    endtask

    task automatic t_first_miss();
        do_reset(1'b0);
        good();
        nogood();
        chk("R4 back to search", oof_alarm, 1);
        chk("R4 irq", irq_cnt, 1);
    endtask

    task automatic t_loss();
        do_reset(1'b0);
        good(); good();
        for (int k = 1; k <= 3; k++) begin
            nogood();
            chk("R5 alarm during miss", oof_alarm, 0);
            chk("R5 in_frame during miss", in_frame, 0);
            chk("R11 pulse in miss frame", p_at0, 1);
        end
        nogood();
        chk("R5 fourth miss alarm", oof_alarm, 1);
        chk("R10 irq once on loss", irq_cnt, 1);
    endtask

    task automatic t_recover();
        do_reset(1'b0);
        good(); good();
        nogood(); nogood(); nogood();
        good();
        chk("R6 relock", in_frame, 1);
        nogood(); nogood(); nogood();
        chk("R6 count restarted", oof_alarm, 0);
        nogood();
        chk("R6 loss after fresh four", oof_alarm, 1);
    endtask

    task automatic t_fast();
        do_reset(1'b1);
        good();
        chk("R7 fast lock", in_frame, 1);
        nogood();
        chk("R7 fast loss", oof_alarm, 1);
        chk("R7 fast irq", irq_cnt, 1);
    endtask

    task automatic t_bytes();
        do_reset(1'b0);
        send_frame(32'hF6F6_F7F6, A2, 0);
        chk("R2 bad A1 byte ignored", oof_alarm, 1);
        send_frame(A1, 32'h2828_2928, 0);
        chk("R2 bad A2 byte ignored", oof_alarm, 1);
        good(); good();
        for (int k = 0; k < 4; k++) send_frame(A1, 32'h2828_2928, 0);
        chk("R2 bad byte counts as miss", oof_alarm, 1);
        chk("R2 irq", irq_cnt, 1);
    endtask

    task automatic t_position();
        do_reset(1'b0);
        good(); good();
        send_frame(A1, A2, 5);
        chk("R8 misplaced marker is bad", in_frame, 0);
        send_frame(A1, A2, 5); send_frame(A1, A2, 5);
        chk("R8 still not lost", oof_alarm, 0);
        send_frame(A1, A2, 5);
        chk("R8 lost after four", irq_cnt, 1);
        chk("R9 search took new phase", oof_alarm, 0);
        chk("R9 not yet locked", in_frame, 0);
        send_frame(A1, A2, 5);
        chk("R9 locked at new phase", in_frame, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regular_lock();
        t_first_miss();
        t_loss();
        t_recover();
        t_fast();
        t_bytes();
        t_position();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule